// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard bookkeeper for an in-order issue pipeline that drives five functional units: one integer/load unit, two multipliers, one add/subtract unit and one divider. Each cycle it looks at one decoded instruction (a two-bit operation class, a destination register and two source registers). It decides whether that instruction may be handed to a unit, and then sequences every unit in flight through operand read, execution and result write. It emits one strobe per unit for each of these steps.

The controller keeps two tables. The per-unit status table holds the busy flag, the register names, the producing units of both sources and the source-ready flags. The per-register table names the unit that will produce each register. Functional units are modelled as latency counters, so the block carries no data values. Operands are read only once both are available. Results are never forwarded. A finished unit waits for write permission while an older instruction still needs the old contents of its destination register.

Top module: `sb_top`

## Requirements
- R1: Class code 0 (integer/load) goes to unit 1, code 1 (multiply) goes to the lowest-numbered free of units 2 and 3, code 2 (add/subtract) goes to unit 4 and code 3 (divide) goes to unit 5. In the cycle an instruction is accepted, `issueOk` is high and `issueUnit` carries the unit number. Otherwise `issueUnit` is 0.
- R2: If no unit of the requested class is free, the instruction is not accepted. It is accepted in the first cycle after its unit has become free.
- R3: An instruction whose destination register still has a pending producer is not accepted, even when its unit is free. It is accepted in the cycle after that producer's write.
- R4: A unit raises its `readVec` bit for exactly one cycle. That cycle is the first one in which neither source has a pending producer, and at the earliest it is the cycle after issue.
- R5: With latency L (defaults: integer/load 1, multiply 10, add/subtract 2, divide 40), a unit that meets no conflict has its `writeVec` bit high L+1 cycles after its read cycle.
- R6: During a write cycle, `writeReg` and `writeOp` show the writer's destination and class. The unit reads as not busy from the next cycle on.
- R7: A write is withheld while any other busy unit still has that register as an unread source.
- R8: A unit waiting on a producer reads its operands in the cycle right after that producer's write.
- R9: At most one unit writes per cycle. Among units eligible in the same cycle, the lower unit number wins and the others wait.
- R10: A unit that has already read its operands never holds back a writer.
- R11: After reset, all units are free, no register has a producer, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | A decoded instruction is presented |
| instOp | input | 2 | Operation class (0 int/load, 1 mul, 2 add/sub, 3 div) |
| instDst | input | 5 | Destination register |
| instSrc1 | input | 5 | First source register |
| instSrc2 | input | 5 | Second source register |
| issueOk | output | 1 | Instruction accepted this cycle |
| issueUnit | output | 3 | Unit receiving the instruction (1..5), 0 if none |
| readVec | output | 5 | Per-unit operand read and execution start strobe |
| writeVec | output | 5 | Per-unit write permission, at most one bit set |
| writeReg | output | 5 | Destination register of the current writer |
| writeOp | output | 2 | Operation class of the current writer |
| busyVec | output | 5 | Per-unit busy flags |

## Verification
On every cycle, the assertions check the local rules of the unit sequence: an instruction goes only to a free unit, which is then busy; reads happen only in busy units and never on two cycles in a row; only one write occurs at a time; and a writer is free in the following cycle. The cross-unit orderings cannot be seen from one cycle's strobes, so only the bench scenarios show them. These include a write held back until a dependent unit has read its old source, a waiting reader released right after its producer's write, a destination-conflict stall lasting a full divide, and the exact cycle counts for each latency.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_UNITS = 5;
  localparam int REG_W     = 5;
  localparam int UID_W     = 3;
  localparam int NUM_REGS  = 1 << REG_W;

  typedef logic [UID_W-1:0] uid_t;
  typedef logic [REG_W-1:0] reg_t;

  typedef enum logic [1:0] {
    OP_INT = 2'd0,
    OP_MUL = 2'd1,
    OP_ADD = 2'd2,
    OP_DIV = 2'd3
  } opClass_t;

  // Full per-unit record kept by the table
  typedef struct packed {
    logic     busy;
    logic     rdDone;
    logic     done;
    opClass_t op;
    reg_t     fi;
    reg_t     fj;
    reg_t     fk;
    uid_t     qj;
    uid_t     qk;
    logic     rj;
    logic     rk;
  } unitStat_t;

  // Subset the control needs for its decisions
  typedef struct packed {
    logic busy;
    logic rdDone;
    logic done;
    reg_t fi;
    reg_t fj;
    reg_t fk;
    logic rj;
    logic rk;
  } unitView_t;

  // Strobes from control to table
  typedef struct packed {
    logic                 issue;
    uid_t                 issueId;
    logic [NUM_UNITS-1:0] readSel;
    logic [NUM_UNITS-1:0] writeSel;
    uid_t                 wrId;
  } sbStrobe_t;

  function automatic opClass_t unitClass(input int u);
    case (u)
      0:       return OP_INT;
      1, 2:    return OP_MUL;
      3:       return OP_ADD;
      default: return OP_DIV;
    endcase
  endfunction
endpackage

// File: rtl/sb_ctrl.sv
module sb_ctrl
  import sb_pkg::*;
(
  input  logic                        instValid,
  input  opClass_t                    instOp,
  input  uid_t                        dstProducer,
  input  unitView_t [NUM_UNITS-1:0]   view,
  output sbStrobe_t                   strobe
);
  uid_t                 pick;
  uid_t                 wrId;
  logic [NUM_UNITS-1:0] conflict;
  logic [NUM_UNITS-1:0] eligible;
  logic                 canIssue;

  // Lowest-numbered free unit of the requested class
  always_comb begin
    pick = '0;
    for (int u = NUM_UNITS - 1; u >= 0; u--) begin
      if (unitClass(u) == instOp && !view[u].busy) pick = uid_t'(u + 1);
    end
  end

  assign canIssue = instValid && (pick != '0) && (dstProducer == '0);

  // Write hold: another unit still wants the old value of our destination
  always_comb begin
    conflict = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      for (int v = 0; v < NUM_UNITS; v++) begin
        if (v != u && view[v].busy &&
            ((view[v].rj && view[v].fj == view[u].fi) ||
             (view[v].rk && view[v].fk == view[u].fi)))
          conflict[u] = 1'b1;
      end
    end
  end

  // Single write port, lower unit number first
  always_comb begin
    wrId = '0;
    for (int u = NUM_UNITS - 1; u >= 0; u--) begin
      eligible[u] = view[u].done && !conflict[u];
      if (eligible[u]) wrId = uid_t'(u + 1);
    end
  end

  always_comb begin
    strobe.issue   = canIssue;
    strobe.issueId = canIssue ? pick : '0;
    strobe.wrId    = wrId;
    for (int u = 0; u < NUM_UNITS; u++) begin
      strobe.readSel[u]  = view[u].busy && !view[u].rdDone && view[u].rj && view[u].rk;
      strobe.writeSel[u] = (wrId == uid_t'(u + 1));
    end
  end
endmodule

// File: rtl/sb_table.sv
module sb_table
  import sb_pkg::*;
#(
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40,
  parameter int CNT_W   = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  sbStrobe_t                 strobe,
  input  opClass_t                  instOp,
  input  reg_t                      instDst,
  input  reg_t                      instSrc1,
  input  reg_t                      instSrc2,
  output unitView_t [NUM_UNITS-1:0] view,
  output uid_t                      dstProducer,
  output reg_t                      writeReg,
  output opClass_t                  writeOp
);
  uid_t      regStat [NUM_REGS];
  unitStat_t stArr   [NUM_UNITS];
  uid_t      effJ;
  uid_t      effK;

  // A producer that writes in the issue cycle is already done
  assign effJ = (regStat[instSrc1] == strobe.wrId) ? '0 : regStat[instSrc1];
  assign effK = (regStat[instSrc2] == strobe.wrId) ? '0 : regStat[instSrc2];
  assign dstProducer = regStat[instDst];

  always_comb begin
    writeReg = '0;
    writeOp  = OP_INT;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (strobe.writeSel[u]) begin
        writeReg = stArr[u].fi;
        writeOp  = stArr[u].op;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regStat[r] <= '0;
    end else begin
      if (strobe.wrId != '0) regStat[writeReg] <= '0;
      if (strobe.issue)      regStat[instDst]  <= strobe.issueId;
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int LAT = (u == 0) ? LAT_INT :
                         (u < 3)  ? LAT_MUL :
                         (u == 3) ? LAT_ADD : LAT_DIV;
    unitStat_t        st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        st  <= '0;
        cnt <= '0;
      end else if (strobe.writeSel[u]) begin
        st  <= '0;
        cnt <= '0;
      end else if (strobe.issue && strobe.issueId == uid_t'(u + 1)) begin
        st.busy   <= 1'b1;
        st.rdDone <= 1'b0;
        st.done   <= 1'b0;
        st.op     <= instOp;
        st.fi     <= instDst;
        st.fj     <= instSrc1;
        st.fk     <= instSrc2;
        st.qj     <= effJ;
        st.qk     <= effK;
        st.rj     <= (effJ == '0);
        st.rk     <= (effK == '0);
      end else if (st.busy) begin
        if (strobe.readSel[u]) begin
          st.rdDone <= 1'b1;
          st.rj     <= 1'b0;
          st.rk     <= 1'b0;
          cnt       <= CNT_W'(LAT - 1);
        end else if (st.rdDone && !st.done) begin
          if (cnt == '0) st.done <= 1'b1;
          else           cnt     <= cnt - 1'b1;
        end
        if (strobe.wrId != '0 && st.qj == strobe.wrId) begin
          st.qj <= '0;
          st.rj <= 1'b1;
        end
        if (strobe.wrId != '0 && st.qk == strobe.wrId) begin
          st.qk <= '0;
          st.rk <= 1'b1;
        end
      end
    end

    assign stArr[u] = st;
    assign view[u]  = '{busy: st.busy, rdDone: st.rdDone, done: st.done,
                        fi: st.fi, fj: st.fj, fk: st.fk, rj: st.rj, rk: st.rk};
  end
endmodule

// File: rtl/sb_top.sv
module sb_top
  import sb_pkg::*;
#(
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 10,
  parameter int LAT_ADD = 2,
  parameter int LAT_DIV = 40
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instValid,
  input  logic [1:0]           instOp,
  input  logic [REG_W-1:0]     instDst,
  input  logic [REG_W-1:0]     instSrc1,
  input  logic [REG_W-1:0]     instSrc2,
  output logic                 issueOk,
  output logic [UID_W-1:0]     issueUnit,
  output logic [NUM_UNITS-1:0] readVec,
  output logic [NUM_UNITS-1:0] writeVec,
  output logic [REG_W-1:0]     writeReg,
  output logic [1:0]           writeOp,
  output logic [NUM_UNITS-1:0] busyVec
);
  localparam int MAX_LAT1 = (LAT_INT > LAT_MUL) ? LAT_INT : LAT_MUL;
  localparam int MAX_LAT2 = (LAT_ADD > LAT_DIV) ? LAT_ADD : LAT_DIV;
  localparam int MAX_LAT  = (MAX_LAT1 > MAX_LAT2) ? MAX_LAT1 : MAX_LAT2;
  localparam int CNT_W    = $clog2(MAX_LAT + 1);

  sbStrobe_t                 strobe;
  unitView_t [NUM_UNITS-1:0] view;
  uid_t                      dstProducer;
  opClass_t                  opIn;
  opClass_t                  wrOp;

  assign opIn = opClass_t'(instOp);

  sb_ctrl u_ctrl (
    .instValid  (instValid),
    .instOp     (opIn),
    .dstProducer(dstProducer),
    .view       (view),
    .strobe     (strobe)
  );

  sb_table #(
    .LAT_INT(LAT_INT), .LAT_MUL(LAT_MUL), .LAT_ADD(LAT_ADD),
    .LAT_DIV(LAT_DIV), .CNT_W(CNT_W)
  ) u_table (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .instOp     (opIn),
    .instDst    (instDst),
    .instSrc1   (instSrc1),
    .instSrc2   (instSrc2),
    .view       (view),
    .dstProducer(dstProducer),
    .writeReg   (writeReg),
    .writeOp    (wrOp)
  );

  assign writeOp   = wrOp;
  assign issueOk   = strobe.issue;
  assign issueUnit = strobe.issueId;
  assign readVec   = strobe.readSel;
  assign writeVec  = strobe.writeSel;
  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) busyVec[u] = view[u].busy;
  end
endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 issueOk,
  input logic [UID_W-1:0]     issueUnit,
  input logic [NUM_UNITS-1:0] readVec,
  input logic [NUM_UNITS-1:0] writeVec,
  input logic [NUM_UNITS-1:0] busyVec
);
  logic [NUM_UNITS-1:0] issueMask;
  always_comb begin
    issueMask = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (issueOk && issueUnit == UID_W'(u + 1)) issueMask[u] = 1'b1;
  end

  assert_issue_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    issueOk |-> (issueMask != '0 && (busyVec & issueMask) == '0));

  assert_issue_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    issueOk |=> ((busyVec & $past(issueMask)) != '0));

  assert_read_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (readVec & ~busyVec) == '0);

  assert_read_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    (readVec != '0) |=> ((readVec & $past(readVec)) == '0));

  assert_one_writer_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(writeVec));

  assert_write_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    (writeVec & ~busyVec) == '0);

  assert_write_frees_R6: assert property (@(posedge clk) disable iff (!rstN)
    (writeVec != '0) |=> ((busyVec & $past(writeVec)) == '0));
endmodule

bind sb_top sb_checker u_sb_checker (
  .clk      (clk),
  .rstN     (rstN),
  .issueOk  (issueOk),
  .issueUnit(issueUnit),
  .readVec  (readVec),
  .writeVec (writeVec),
  .busyVec  (busyVec)
);

// File: tb/test_sb_top.sv
module test_sb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       instValid = 1'b0;
  logic [1:0] instOp = 2'd0;
  logic [4:0] instDst = 5'd0;
  logic [4:0] instSrc1 = 5'd0;
  logic [4:0] instSrc2 = 5'd0;
  logic       issueOk;
  logic [2:0] issueUnit;
  logic [4:0] readVec;
  logic [4:0] writeVec;
  logic [4:0] writeReg;
  logic [1:0] writeOp;
  logic [4:0] busyVec;

  int testCnt = 0;
  int failCnt = 0;

  always #4 clk = ~clk;

  sb_top i_sb_top (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instOp(instOp),
    .instDst(instDst), .instSrc1(instSrc1), .instSrc2(instSrc2),
    .issueOk(issueOk), .issueUnit(issueUnit), .readVec(readVec),
    .writeVec(writeVec), .writeReg(writeReg), .writeOp(writeOp),
    .busyVec(busyVec)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [4:0] dst;
    logic [4:0] s1;
    logic [4:0] s2;
    logic [2:0] unitId;
    logic [7:0] lat;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{2'd0, 5'd1,  5'd2,  5'd3,  3'd1, 8'd1},
    '{2'd1, 5'd4,  5'd5,  5'd6,  3'd2, 8'd10},
    '{2'd2, 5'd7,  5'd8,  5'd9,  3'd4, 8'd2},
    '{2'd3, 5'd10, 5'd11, 5'd12, 3'd5, 8'd40},
    '{2'd1, 5'd13, 5'd13, 5'd14, 3'd2, 8'd10}
  };

  task automatic check(input string req, input int act, input int exp);
    testCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op, input logic [4:0] d,
                       input logic [4:0] a, input logic [4:0] b);
    instValid = v; instOp = op; instDst = d; instSrc1 = a; instSrc2 = b;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); #1;
      if (busyVec == 5'd0) break;
    end
    check("R6 idle", busyVec, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R11 reset state
    check("R11 busy", busyVec, 0);
    check("R11 read", readVec, 0);
    check("R11 write", writeVec, 0);
    check("R11 issue", issueOk, 0);

    // R1 R4 R5 R6 table walk from idle
    for (int i = 0; i < 5; i++) begin
      int k;
      @(negedge clk);
      drive(1'b1, VECS[i].op, VECS[i].dst, VECS[i].s1, VECS[i].s2);
      #1;
      check("R1 issueOk", issueOk, 1);
      check("R1 issueUnit", issueUnit, VECS[i].unitId);
      @(negedge clk);
      drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
      #1;
      check("R4 read after issue", readVec, 1 << (VECS[i].unitId - 1));
      k = 1;
      for (int c = 0; c < 60; c++) begin
        @(negedge clk); #1;
        k++;
        if (writeVec != 5'd0) break;
      end
      check("R5 latency", k, VECS[i].lat + 2);
      check("R6 writeVec", writeVec, 1 << (VECS[i].unitId - 1));
      check("R6 writeReg", writeReg, VECS[i].dst);
      check("R6 writeOp", writeOp, VECS[i].op);
      @(negedge clk); #1;
      check("R6 freed", busyVec, 0);
    end

    // R2 structural stall on multipliers
    @(negedge clk); drive(1'b1, 2'd1, 5'd1, 5'd2, 5'd3); #1;
    check("R1 mul A", issueUnit, 2);
    @(negedge clk); drive(1'b1, 2'd1, 5'd7, 5'd8, 5'd9); #1;
    check("R1 mul B", issueUnit, 3);
    @(negedge clk); drive(1'b1, 2'd1, 5'd10, 5'd11, 5'd12); #1;
    check("R2 stall", issueOk, 0);
    begin
      int held = 1;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk); #1;
        if (issueOk) break;
        held++;
      end
      check("R2 stall length", held, 11);
      check("R2 reuse unit", issueUnit, 2);
    end
    @(negedge clk); drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
    waitIdle();

    // R3 destination conflict stall
    @(negedge clk); drive(1'b1, 2'd3, 5'd4, 5'd5, 5'd6); #1;
    check("R1 div", issueUnit, 5);
    @(negedge clk); drive(1'b1, 2'd2, 5'd4, 5'd7, 5'd8); #1;
    check("R3 stall", issueOk, 0);
    check("R3 unit free", busyVec[3], 0);
    begin
      int n = 1;
      for (int c = 0; c < 80; c++) begin
        @(negedge clk); #1;
        n++;
        if (issueOk) break;
      end
      check("R3 issue cycle", n, 43);
    end
    @(negedge clk); drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
    waitIdle();

    // R7 R8 R10 dependency chain
    @(negedge clk); drive(1'b1, 2'd1, 5'd1, 5'd2, 5'd3); #1;   // n0 mul r1
    check("R1 chain mul", issueUnit, 2);
    @(negedge clk); drive(1'b1, 2'd2, 5'd5, 5'd1, 5'd6); #1;   // n1 add r5 <- r1,r6
    check("R1 chain add", issueUnit, 4);
    check("R4 mul reads", readVec, 5'b00010);
    @(negedge clk); drive(1'b1, 2'd0, 5'd6, 5'd7, 5'd7); #1;   // n2 int r6
    check("R1 chain int", issueUnit, 1);
    check("R4 add waits", readVec, 0);
    @(negedge clk); drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0); #1;  // n3
    check("R4 int reads", readVec, 5'b00001);
    repeat (2) @(negedge clk); #1;                               // n5
    check("R7 int held", writeVec, 0);
    repeat (7) @(negedge clk); #1;                               // n12
    check("R5 mul write", writeVec, 5'b00010);
    check("R6 mul reg", writeReg, 1);
    @(negedge clk); #1;                                          // n13
    check("R8 add wakes", readVec, 5'b01000);
    check("R7 int still held", writeVec, 0);
    @(negedge clk); #1;                                          // n14
    check("R10 int writes", writeVec, 5'b00001);
    check("R10 int reg", writeReg, 6);
    repeat (2) @(negedge clk); #1;                               // n16
    check("R5 add write", writeVec, 5'b01000);
    check("R6 add reg", writeReg, 5);
    waitIdle();

    // R9 write port priority
    @(negedge clk); drive(1'b1, 2'd2, 5'd10, 5'd11, 5'd12); #1;
    check("R1 prio add", issueUnit, 4);
    @(negedge clk); drive(1'b1, 2'd0, 5'd13, 5'd14, 5'd14); #1;
    check("R1 prio int", issueUnit, 1);
    @(negedge clk); drive(1'b0, 2'd0, 5'd0, 5'd0, 5'd0);
    repeat (2) @(negedge clk); #1;                               // n4
    check("R9 low wins", writeVec, 5'b00001);
    check("R9 low reg", writeReg, 13);
    @(negedge clk); #1;                                          // n5
    check("R9 loser next", writeVec, 5'b01000);
    check("R9 loser reg", writeReg, 10);
    waitIdle();

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule